// File: doc/BRIEF.md
# StreamID Event Qualifier

This block sits in front of a bank of event counters inside an address-translation unit. On each clock it looks at one incoming event: a valid strobe, a 16-bit event code and a StreamID. For every counter it raises a one-cycle increment qualifier when two things hold. The event code must equal the code that counter has selected. The StreamID must pass that counter's filter.

Each counter's filter is a span bit and a match value. With the span bit clear, the StreamID must equal the match value exactly. With the span bit set, a run of low-order bits is ignored. That run is marked inside the match value itself: its lowest zero bit and every one bit below that zero. The low bits of a match value of all ones are all ones, so that setting lets every StreamID through. This is the setting used when a counter should not filter at all.

A shared-filter input makes counter 0's span and match value govern every counter, while each counter keeps its own event code. The counters themselves, register decoding and interrupts live elsewhere.

Top module: `sidf_event_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `cnt_inc_o` is 0.
- R2: The qualifier is registered. An event presented in one clock cycle shows on `cnt_inc_o` after the next rising edge. It lasts a single cycle unless another qualifying event follows.
- R3: Bits [15:0] of a counter's type word hold its event code, and bit 29 holds its span bit. With the span bit clear, an event passes only when its StreamID equals the match value in every bit.
- R4: With the span bit set and match value 0x42, StreamIDs 0x42 and 0x43 pass, while 0x40 and 0x44 do not.
- R5: With the span bit set, the ignored bits are those below and including the lowest zero bit of the match value. With match value 0x47, StreamIDs 0x40 through 0x4F pass, while 0x3F and 0x50 do not.
- R6: With the span bit set and a match value of all ones, every StreamID passes. With the span bit clear and a match value of all ones, StreamID 0 does not pass.
- R7: A counter whose event code differs from the incoming event code is not incremented, even when the StreamID passes.
- R8: A counter whose event code is 0 (cycles) is incremented on every clock. The valid strobe, the incoming code and the StreamID make no difference to it.
- R9: With `cfg_shared_i` high, every counter uses counter 0's span bit and match value together with its own event code. Two counters with the same code then produce identical qualifiers.
- R10: With `cfg_shared_i` low, each counter uses its own span bit and match value.
- R11: When the valid strobe is low, no counter with a non-zero event code is incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | An event is present this cycle |
| evt_code_i | input | 16 | Event code of the incoming event |
| evt_sid_i | input | SID_W | StreamID of the incoming event |
| cfg_shared_i | input | 1 | 1: counter 0's filter applies to all counters |
| cfg_type_i | input | NUM_CTR*32 | Per-counter type words: code in [15:0], span in bit 29 |
| cfg_match_i | input | NUM_CTR*SID_W | Per-counter StreamID match values |
| cnt_inc_o | output | NUM_CTR | Registered per-counter increment qualifiers |

## Verification
The assertions check the following on every cycle:
- the quiet reset state;
- the constant firing of the cycles event;
- silence when the strobe is low or the event code differs;
- a hit on an exact match;
- a pass for the all-ones span value;
- matching qualifiers for counters that share a filter and a code.

The following can only be shown by the bench's scenarios, because each depends on chosen match values and on a pass/fail boundary:
- which StreamIDs sit on either side of a span boundary (0x42 against 0x44, 0x4F against 0x50);
- how per-counter filters differ from one another;
- the one-cycle latency of the registered output.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    localparam int EVT_W    = 16;
    localparam int TYPE_W   = 32;
    localparam int SPAN_BIT = 29;

    typedef enum logic [EVT_W-1:0] {
        EV_CYCLES      = 16'd0,
        EV_XACT        = 16'd1,
        EV_TLB_MISS    = 16'd2,
        EV_CFGC_MISS   = 16'd3,
        EV_WALK_ACC    = 16'd4,
        EV_CFGS_ACC    = 16'd5,
        EV_ATS_REQ     = 16'd6,
        EV_ATS_PASS    = 16'd7
    } sidf_evt_e;

endpackage

// File: rtl/sidf_span_match.sv
module sidf_span_match #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] sid_i,
    input  logic [SID_W-1:0] match_i,
    input  logic             span_i,
    output logic             pass_o
);

    logic [SID_W-1:0] dont_care;
    logic [SID_W-1:0] diff;

    always_comb begin
        // Lowest zero of match plus the ones below it flip on +1.
        dont_care = span_i ? (match_i ^ (match_i + SID_W'(1))) : '0;
        diff      = (sid_i ^ match_i) & ~dont_care;
        pass_o    = (diff == '0);
    end

endmodule

// File: rtl/sidf_setting_sel.sv
module sidf_setting_sel
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32
) (
    input  logic                      shared_i,
    input  logic [NUM_CTR*TYPE_W-1:0] type_i,
    input  logic [NUM_CTR*SID_W-1:0]  match_i,
    output logic [NUM_CTR*EVT_W-1:0]  code_o,
    output logic [NUM_CTR-1:0]        span_o,
    output logic [NUM_CTR*SID_W-1:0]  match_o
);

    logic base_span;
    logic [SID_W-1:0] base_match;

    assign base_span  = type_i[SPAN_BIT];
    assign base_match = match_i[0 +: SID_W];

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
        logic [TYPE_W-1:0] word;
        logic              unused_bits;
        assign word = type_i[g*TYPE_W +: TYPE_W];
        assign code_o[g*EVT_W +: EVT_W] = word[EVT_W-1:0];
        assign span_o[g]  = shared_i ? base_span : word[SPAN_BIT];
        assign match_o[g*SID_W +: SID_W] =
            shared_i ? base_match : match_i[g*SID_W +: SID_W];
        assign unused_bits = ^{word[TYPE_W-1:SPAN_BIT+1], word[SPAN_BIT-1:EVT_W]};
    end

endmodule

// File: rtl/sidf_lane.sv
module sidf_lane
    import sidf_pkg::*;
#(
    parameter int SID_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_valid_i,
    input  logic [EVT_W-1:0] evt_code_i,
    input  logic [SID_W-1:0] evt_sid_i,
    input  logic [EVT_W-1:0] lane_code_i,
    input  logic             lane_span_i,
    input  logic [SID_W-1:0] lane_match_i,
    output logic             inc_o
);

    typedef struct packed {
        logic inc;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     sid_pass;
    logic     is_cycles;

    sidf_span_match #(.SID_W(SID_W)) u_match (
        .sid_i   (evt_sid_i),
        .match_i (lane_match_i),
        .span_i  (lane_span_i),
        .pass_o  (sid_pass)
    );

    always_comb begin
        st_d      = st_q;
        is_cycles = (lane_code_i == EV_CYCLES);
        if (is_cycles) begin
            st_d.inc = 1'b1;
        end else begin
            st_d.inc = evt_valid_i && (evt_code_i == lane_code_i) && sid_pass;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_o = st_q.inc;

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !inc_o);

    p_cycles_every_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lane_code_i == EV_CYCLES) |=> inc_o);

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!evt_valid_i && lane_code_i != EV_CYCLES) |=> !inc_o);

    p_code_mismatch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lane_code_i != EV_CYCLES && evt_code_i != lane_code_i) |=> !inc_o);

    p_exact_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_i && evt_code_i == lane_code_i && !lane_span_i &&
         evt_sid_i == lane_match_i) |=> inc_o);

    p_all_ones_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_i && evt_code_i == lane_code_i && lane_span_i &&
         (&lane_match_i)) |=> inc_o);

endmodule

// File: rtl/sidf_event_qualifier.sv
module sidf_event_qualifier
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      evt_valid_i,
    input  logic [EVT_W-1:0]          evt_code_i,
    input  logic [SID_W-1:0]          evt_sid_i,
    input  logic                      cfg_shared_i,
    input  logic [NUM_CTR*TYPE_W-1:0] cfg_type_i,
    input  logic [NUM_CTR*SID_W-1:0]  cfg_match_i,
    output logic [NUM_CTR-1:0]        cnt_inc_o
);

    logic [NUM_CTR*EVT_W-1:0] sel_code;
    logic [NUM_CTR-1:0]       sel_span;
    logic [NUM_CTR*SID_W-1:0] sel_match;

    sidf_setting_sel #(.NUM_CTR(NUM_CTR), .SID_W(SID_W)) u_sel (
        .shared_i (cfg_shared_i),
        .type_i   (cfg_type_i),
        .match_i  (cfg_match_i),
        .code_o   (sel_code),
        .span_o   (sel_span),
        .match_o  (sel_match)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_lane
        sidf_lane #(.SID_W(SID_W)) u_lane (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .evt_valid_i  (evt_valid_i),
            .evt_code_i   (evt_code_i),
            .evt_sid_i    (evt_sid_i),
            .lane_code_i  (sel_code[g*EVT_W +: EVT_W]),
            .lane_span_i  (sel_span[g]),
            .lane_match_i (sel_match[g*SID_W +: SID_W]),
            .inc_o        (cnt_inc_o[g])
        );
    end

    for (genvar g = 1; g < NUM_CTR; g++) begin : g_shared_chk
        p_shared_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_shared_i &&
             cfg_type_i[g*TYPE_W +: EVT_W] == cfg_type_i[0 +: EVT_W])
            |=> (cnt_inc_o[g] == cnt_inc_o[0]));
    end

endmodule

// File: tb/sidf_event_qualifier_tb_top.sv
module sidf_event_qualifier_tb_top;
    import sidf_pkg::*;

    localparam int  NC     = 4;
    localparam int  SW     = 32;
    localparam time CLK_PD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid = 1'b0;
    logic [EVT_W-1:0]  code = '0;
    logic [SW-1:0]     sid = '0;
    logic              shared = 1'b0;
    logic [NC*TYPE_W-1:0] type_v = '0;
    logic [NC*SW-1:0]  match_v = '0;
    logic [NC-1:0]     inc;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    sidf_event_qualifier #(.NUM_CTR(NC), .SID_W(SW)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .evt_valid_i  (valid),
        .evt_code_i   (code),
        .evt_sid_i    (sid),
        .cfg_shared_i (shared),
        .cfg_type_i   (type_v),
        .cfg_match_i  (match_v),
        .cnt_inc_o    (inc)
    );

    task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: cnt_inc_o actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_ctr(input int idx, input logic [EVT_W-1:0] c,
                           input logic sp, input logic [SW-1:0] m);
        logic [TYPE_W-1:0] w;
        w = '0;
        w[EVT_W-1:0] = c;
        w[SPAN_BIT]  = sp;
        type_v[idx*TYPE_W +: TYPE_W] = w;
        match_v[idx*SW +: SW] = m;
    endtask

    task automatic park_all();
        for (int i = 0; i < NC; i++) set_ctr(i, 16'hFFFF, 1'b0, '0);
        shared = 1'b0;
    endtask

    // Drive one cycle of stimulus and check the registered result.
    task automatic step(input string req, input logic v, input logic [EVT_W-1:0] c,
                        input logic [SW-1:0] s, input logic [NC-1:0] exp);
        @(negedge clk);
        valid = v; code = c; sid = s;
        @(posedge clk);
        #1;
        chk(req, inc, exp);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R1 during reset", inc, '0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", inc, '0);
    endtask

    task automatic t_exact();
        @(negedge clk); park_all();
        set_ctr(0, EV_XACT, 1'b0, 32'h0000_1234);
        step("R3 exact hit", 1'b1, EV_XACT, 32'h1234, 4'b0001);
        step("R2 single pulse", 1'b0, EV_XACT, 32'h1234, 4'b0000);
        step("R3 one bit off", 1'b1, EV_XACT, 32'h1235, 4'b0000);
        step("R2 back to back a", 1'b1, EV_XACT, 32'h1234, 4'b0001);
        step("R2 back to back b", 1'b1, EV_XACT, 32'h1234, 4'b0001);
        step("R11 strobe low", 1'b0, EV_XACT, 32'h1234, 4'b0000);
    endtask

    task automatic t_span_pair();
        @(negedge clk); park_all();
        set_ctr(0, EV_TLB_MISS, 1'b1, 32'h42);
        step("R4 0x42", 1'b1, EV_TLB_MISS, 32'h42, 4'b0001);
        step("R4 0x43", 1'b1, EV_TLB_MISS, 32'h43, 4'b0001);
        step("R4 0x40", 1'b1, EV_TLB_MISS, 32'h40, 4'b0000);
        step("R4 0x44", 1'b1, EV_TLB_MISS, 32'h44, 4'b0000);
    endtask

    task automatic t_span_wide();
        @(negedge clk); park_all();
        set_ctr(1, EV_WALK_ACC, 1'b1, 32'h47);
        step("R5 0x40", 1'b1, EV_WALK_ACC, 32'h40, 4'b0010);
        step("R5 0x4F", 1'b1, EV_WALK_ACC, 32'h4F, 4'b0010);
        step("R5 0x3F", 1'b1, EV_WALK_ACC, 32'h3F, 4'b0000);
        step("R5 0x50", 1'b1, EV_WALK_ACC, 32'h50, 4'b0000);
    endtask

    task automatic t_all_ones();
        @(negedge clk); park_all();
        set_ctr(2, EV_ATS_REQ, 1'b1, 32'hFFFF_FFFF);
        set_ctr(3, EV_ATS_REQ, 1'b0, 32'hFFFF_FFFF);
        step("R6 span zero sid", 1'b1, EV_ATS_REQ, 32'h0, 4'b0100);
        step("R6 span any sid", 1'b1, EV_ATS_REQ, 32'hDEAD_BEEF, 4'b0100);
        step("R6 exact all ones", 1'b1, EV_ATS_REQ, 32'hFFFF_FFFF, 4'b1100);
    endtask

    task automatic t_code();
        @(negedge clk); park_all();
        set_ctr(0, EV_CFGC_MISS, 1'b1, 32'hFFFF_FFFF);
        step("R7 code differs", 1'b1, EV_CFGS_ACC, 32'h5, 4'b0000);
        step("R7 code equal", 1'b1, EV_CFGC_MISS, 32'h5, 4'b0001);
    endtask

    task automatic t_cycles();
        @(negedge clk); park_all();
        set_ctr(3, EV_CYCLES, 1'b0, 32'h1);
        step("R8 idle", 1'b0, EV_XACT, 32'h0, 4'b1000);
        step("R8 other code", 1'b1, EV_ATS_PASS, 32'h99, 4'b1000);
        step("R8 sid mismatch", 1'b1, EV_CYCLES, 32'h77, 4'b1000);
    endtask

    task automatic t_per_counter();
        @(negedge clk); park_all();
        set_ctr(0, EV_XACT, 1'b0, 32'h10);
        set_ctr(1, EV_XACT, 1'b0, 32'h20);
        step("R10 own filter ctr1", 1'b1, EV_XACT, 32'h20, 4'b0010);
        step("R10 own filter ctr0", 1'b1, EV_XACT, 32'h10, 4'b0001);
    endtask

    task automatic t_shared();
        @(negedge clk); park_all();
        set_ctr(0, EV_XACT, 1'b0, 32'h10);
        set_ctr(1, EV_XACT, 1'b0, 32'h20);
        set_ctr(2, EV_TLB_MISS, 1'b1, 32'hFFFF_FFFF);
        shared = 1'b1;
        step("R9 base filter on all", 1'b1, EV_XACT, 32'h10, 4'b0011);
        step("R9 own match ignored", 1'b1, EV_XACT, 32'h20, 4'b0000);
        step("R9 own code kept", 1'b1, EV_TLB_MISS, 32'h10, 4'b0100);
        step("R9 own span ignored", 1'b1, EV_TLB_MISS, 32'h11, 4'b0000);
    endtask

    initial begin
        park_all();
        t_reset();
        t_exact();
        t_span_pair();
        t_span_wide();
        t_all_ones();
        t_code();
        t_cycles();
        t_per_counter();
        t_shared();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule